// File: doc/BRIEF.md
# Interrupt Request Latch and Rotating Priority Resolver

This block takes in eight raw interrupt request lines and decides which one, if any, goes to the processor. Each line is set up on its own as edge sensitive or level sensitive. A rising edge on an edge line leaves a pending bit that stays set until a side-band clear strobe removes it. A level line's pending bit simply tracks the input.

Pending lines that are not masked compete under a rotating priority. A programmable offset names the physical line that holds the top slot, and priority falls from there in circular order. The winner is then held against the highest-priority line already in service, and it is presented only if it ranks strictly above that line. On the master unit an optional nested mode leaves the cascade line out of the in-service comparison. This lets a further request arriving through the cascade pass through.

Register programming and the acknowledge handshake sit outside the block. The mask, in-service and trigger-mode registers, the offset and the nested flag come in as plain inputs. The acknowledge path clears edge requests through the per-line clear strobe.

Top module: `irq_prio_resolver`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, the request-valid output is 0. Reset clears every pending bit and the stored previous input levels.
- R2: For a line whose trigger-mode bit is 0 (edge), the pending bit is set only when the input is high and the level sampled one clock earlier was low. An input that stays high after its pending bit was cleared does not set it again.
- R3: An edge-mode pending bit stays set after its input falls. It is cleared on a clock edge where its clear strobe bit is 1 and no new rising edge is seen on that line.
- R4: For a line whose trigger-mode bit is 1 (level), the pending bit equals the input level sampled at the previous clock edge. The clear strobe has no effect on such a line.
- R5: A line whose mask bit is 1 never wins. When its mask bit returns to 0 it competes again.
- R6: Relative priority index i (0 highest, 7 lowest) belongs to physical line (i + offset) mod 8. Among unmasked pending lines the smallest relative index wins.
- R7: A request is presented only if its relative index is strictly smaller than the relative index of the highest-priority in-service bit. With no bit in service, that index is taken as 8. An equal index gives no request.
- R8: In the master build (the default), with the nested flag at 1, in-service bit 2 (the cascade line) is left out of the in-service comparison. With the flag at 0 it counts like any other bit.
- R9: The reported 3-bit line number is (winning relative index + offset) mod 8, which is the physical line number.
- R10: The outputs are registered. A change of a request input appears at the outputs two clock edges later. A change of mask, in-service, offset or nested flag appears one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Raw request levels, one per line |
| trig_level | input | 8 | Trigger mode per line: 1 level, 0 edge |
| mask_reg | input | 8 | Mask per line: 1 blocks the line |
| isr_reg | input | 8 | In-service bits per line |
| rot_base | input | 3 | Rotation offset: physical line holding relative index 0 |
| nest_en | input | 1 | Nested mode: drop the cascade line from the in-service comparison |
| req_clr | input | 8 | Per-line clear strobe for edge-mode pending bits |
| int_valid | output | 1 | A request is presented to the processor |
| int_line | output | 3 | Physical number of the presented line |

## Verification
The only state the block keeps is the pending and previous-level bits. A wrong value in either shows up two edges after the input pattern that caused it, as a valid output that fails to rise, or rises on the wrong line. The bench covers the following cases:
- an edge line that stays high after being cleared, which exposes a stale history bit as a spurious second request;
- a level line that ignores its clear strobe, which exposes a clear wrongly applied to it as a request that disappears;
- rotation offsets that push a line from the last slot to the first, which expose index arithmetic that is off by one;
- in-service patterns at, above and below the winner's rank, which expose errors in the strict comparison and in the cascade exclusion.

All of these appear at the ports within one or two cycles.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int unsigned NLINES = 8;
    localparam int unsigned IDX_W  = $clog2(NLINES);

    typedef logic [NLINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0]  line_idx_t;
    // One bit wider than an index so that NLINES can mean "none found"
    typedef logic [IDX_W:0]    prio_t;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic      valid;
        line_idx_t line;
    } grant_t;

    localparam prio_t PRIO_NONE = prio_t'(NLINES);

    function automatic line_idx_t rel_to_phys(prio_t rel, line_idx_t rot);
        return line_idx_t'(rel[IDX_W-1:0] + rot);
    endfunction

endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_prio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_lvl,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       pend_q,
    output logic       hist_q
);

    logic rise;
    assign rise = irq_lvl & ~hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            hist_q <= irq_lvl;
            unique case (mode)
                TRIG_LEVEL: pend_q <= irq_lvl;
                TRIG_EDGE: begin
                    // A fresh edge has priority over a clear in the same cycle
                    if (rise)
                        pend_q <= 1'b1;
                    else if (clr)
                        pend_q <= 1'b0;
                end
                default: pend_q <= pend_q;
            endcase
        end
    end

endmodule

// File: rtl/irq_prio_search.sv
module irq_prio_search
    import irq_prio_pkg::*;
(
    input  line_vec_t vec,
    input  line_idx_t rot,
    output prio_t     prio
);

    line_vec_t rel_hit;

    // Reorder the vector so bit i is relative priority i
    for (genvar i = 0; i < NLINES; i++) begin : g_rel
        localparam line_idx_t REL = line_idx_t'(i);
        line_idx_t phys;
        assign phys       = REL + rot;
        assign rel_hit[i] = vec[phys];
    end

    always_comb begin
        prio = PRIO_NONE;
        for (int k = NLINES - 1; k >= 0; k--) begin
            if (rel_hit[k])
                prio = prio_t'(k);
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_prio_pkg::*;
#(
    parameter bit          IS_MASTER    = 1'b1,
    parameter int unsigned CASCADE_LINE = 2
) (
    input  line_vec_t pend,
    input  line_vec_t mask,
    input  line_vec_t isr,
    input  line_idx_t rot,
    input  logic      nest_en,
    output grant_t    grant
);

    line_vec_t cand;
    line_vec_t isr_eff;
    prio_t     req_prio;
    prio_t     svc_prio;

    assign cand = pend & ~mask;

    if (IS_MASTER) begin : g_master
        always_comb begin
            isr_eff = isr;
            if (nest_en)
                isr_eff[CASCADE_LINE] = 1'b0;
        end
    end else begin : g_slave
        assign isr_eff = isr;
    end

    irq_prio_search u_req_search (
        .vec  (cand),
        .rot  (rot),
        .prio (req_prio)
    );

    irq_prio_search u_svc_search (
        .vec  (isr_eff),
        .rot  (rot),
        .prio (svc_prio)
    );

    always_comb begin
        grant.valid = (req_prio < svc_prio);
        grant.line  = rel_to_phys(req_prio, rot);
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter bit          IS_MASTER    = 1'b1,
    parameter int unsigned CASCADE_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NLINES-1:0]    irq_in,
    input  logic [NLINES-1:0]    trig_level,
    input  logic [NLINES-1:0]    mask_reg,
    input  logic [NLINES-1:0]    isr_reg,
    input  logic [IDX_W-1:0]     rot_base,
    input  logic                 nest_en,
    input  logic [NLINES-1:0]    req_clr,
    output logic                 int_valid,
    output logic [IDX_W-1:0]     int_line
);

    line_vec_t pend_q;
    line_vec_t hist_q;
    grant_t    grant_d;
    grant_t    grant_q;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        irq_req_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .irq_lvl (irq_in[i]),
            .mode    (trig_mode_e'(trig_level[i])),
            .clr     (req_clr[i]),
            .pend_q  (pend_q[i]),
            .hist_q  (hist_q[i])
        );
    end

    irq_prio_arbiter #(
        .IS_MASTER    (IS_MASTER),
        .CASCADE_LINE (CASCADE_LINE)
    ) u_arb (
        .pend    (pend_q),
        .mask    (mask_reg),
        .isr     (isr_reg),
        .rot     (rot_base),
        .nest_en (nest_en),
        .grant   (grant_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= '0;
        else
            grant_q <= grant_d;
    end

    assign int_valid = grant_q.valid;
    assign int_line  = grant_q.line;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
    import irq_prio_pkg::*;
#(
    parameter bit          IS_MASTER    = 1'b1,
    parameter int unsigned CASCADE_LINE = 2
) (
    input logic      clk,
    input logic      rst,
    input line_vec_t irq_in,
    input line_vec_t trig_level,
    input line_vec_t mask_reg,
    input line_vec_t isr_reg,
    input logic      nest_en,
    input line_vec_t req_clr,
    input line_vec_t pend_q,
    input line_vec_t hist_q,
    input logic      int_valid,
    input line_idx_t int_line
);

    line_vec_t mask_d, isr_d, pend_d;
    logic      nest_d;

    always_ff @(posedge clk) begin
        mask_d <= mask_reg;
        isr_d  <= isr_reg;
        pend_d <= pend_q;
        nest_d <= nest_en;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !int_valid);

    for (genvar k = 0; k < NLINES; k++) begin : g_ln
        assert_edge_rise_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig_level[k]) && $rose(pend_q[k]))
            |-> ($past(irq_in[k]) && !$past(hist_q[k])));

        assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(trig_level[k]) && $past(pend_q[k]) && !$past(req_clr[k]))
            |-> pend_q[k]);

        assert_level_track_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(trig_level[k]))
            |-> (pend_q[k] == $past(irq_in[k])));
    end

    assert_unmasked_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int_valid) |-> !mask_d[int_line]);

    assert_pending_src_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int_valid) |-> pend_d[int_line]);

    assert_beats_service_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int_valid
         && !(IS_MASTER && nest_d && int_line == line_idx_t'(CASCADE_LINE)))
        |-> !isr_d[int_line]);

endmodule

bind irq_prio_resolver irq_prio_chk #(
    .IS_MASTER    (IS_MASTER),
    .CASCADE_LINE (CASCADE_LINE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .trig_level (trig_level),
    .mask_reg   (mask_reg),
    .isr_reg    (isr_reg),
    .nest_en    (nest_en),
    .req_clr    (req_clr),
    .pend_q     (pend_q),
    .hist_q     (hist_q),
    .int_valid  (int_valid),
    .int_line   (int_line)
);

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in, trig_level, mask_reg, isr_reg, req_clr;
    logic [2:0] rot_base;
    logic       nest_en;
    logic       int_valid;
    logic [2:0] int_line;

    always #4 clk = ~clk;

    irq_prio_resolver u_irq_prio_resolver (
        .clk        (clk),
        .rst        (rst),
        .irq_in     (irq_in),
        .trig_level (trig_level),
        .mask_reg   (mask_reg),
        .isr_reg    (isr_reg),
        .rot_base   (rot_base),
        .nest_en    (nest_en),
        .req_clr    (req_clr),
        .int_valid  (int_valid),
        .int_line   (int_line)
    );

    typedef struct {
        int         due;
        logic       v;
        logic [2:0] ln;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expected result lat edges from now
    task automatic expect_at(int lat, logic v, logic [2:0] ln, string tag);
        exp_t e;
        e.due = cyc + lat;
        e.v   = v;
        e.ln  = ln;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_t e;
                e = sbq.pop_front();
                n_run++;
                if (e.due != cyc || int_valid !== e.v || (e.v && int_line !== e.ln)) begin
                    n_fail++;
                    $display("FAIL %s cyc=%0d: got valid=%b line=%0d, expected valid=%b line=%0d",
                             e.tag, cyc, int_valid, int_line, e.v, e.ln);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = 8'hFF; trig_level = 8'hFF; mask_reg = 8'h00;
        isr_reg = 8'h00; rot_base = 3'd0; nest_en = 1'b0; req_clr = 8'h00;
        tick(3);
        expect_at(1, 1'b0, 3'd0, "R1");          // reset holds valid low
        tick(1);
        irq_in = 8'h00; trig_level = 8'h00;
        tick(1);
        rst = 1'b0;
        expect_at(2, 1'b0, 3'd0, "R1");
        tick(2);

        // R2: rising edge on line 3
        irq_in = 8'h08;
        expect_at(2, 1'b1, 3'd3, "R2");
        tick(2);
        // R3: input drops, request held
        irq_in = 8'h00;
        expect_at(2, 1'b1, 3'd3, "R3");
        tick(2);
        req_clr = 8'h08;
        expect_at(2, 1'b0, 3'd0, "R3");
        tick(1); req_clr = 8'h00; tick(1);

        // R2: held high after clear does not retrigger
        irq_in = 8'h08;
        expect_at(2, 1'b1, 3'd3, "R2");
        tick(2);
        req_clr = 8'h08;
        expect_at(2, 1'b0, 3'd0, "R2");
        tick(1); req_clr = 8'h00; tick(1);
        expect_at(2, 1'b0, 3'd0, "R2");
        tick(2);

        // R4: level line 5 ignores clear, follows input
        trig_level = 8'h20; irq_in = 8'h28;
        expect_at(2, 1'b1, 3'd5, "R4");
        tick(2);
        req_clr = 8'h20;
        expect_at(2, 1'b1, 3'd5, "R4");
        tick(1); req_clr = 8'h00; tick(1);
        irq_in = 8'h08;
        expect_at(2, 1'b0, 3'd0, "R4");
        tick(2);
        irq_in = 8'h00; tick(2);

        // R5 / R10: masking with one-edge config latency
        irq_in = 8'h20;
        expect_at(2, 1'b1, 3'd5, "R5");
        tick(2);
        mask_reg = 8'h20;
        expect_at(1, 1'b0, 3'd0, "R10");
        tick(2);
        mask_reg = 8'h00;
        expect_at(1, 1'b1, 3'd5, "R5");
        tick(2);

        // R6 / R9: rotation with lines 1 and 6 pending
        trig_level = 8'hFF; irq_in = 8'h42;
        expect_at(2, 1'b1, 3'd1, "R6");
        tick(2);
        rot_base = 3'd2;
        expect_at(1, 1'b1, 3'd6, "R6");
        tick(2);
        rot_base = 3'd7;
        expect_at(1, 1'b1, 3'd1, "R9");
        tick(2);
        rot_base = 3'd6;
        expect_at(1, 1'b1, 3'd6, "R9");
        tick(2);
        rot_base = 3'd0;

        // R7: strict comparison against in-service
        isr_reg = 8'h02;
        expect_at(1, 1'b0, 3'd0, "R7");
        tick(2);
        isr_reg = 8'h01;
        expect_at(1, 1'b0, 3'd0, "R7");
        tick(2);
        isr_reg = 8'h10;
        expect_at(1, 1'b1, 3'd1, "R7");
        tick(2);
        irq_in = 8'h40;
        expect_at(2, 1'b0, 3'd0, "R7");
        tick(2);
        isr_reg = 8'h00;
        expect_at(1, 1'b1, 3'd6, "R7");
        tick(2);

        // R8: nested mode drops cascade line 2 from in-service
        irq_in = 8'h04; isr_reg = 8'h04;
        expect_at(2, 1'b0, 3'd0, "R8");
        tick(2);
        nest_en = 1'b1;
        expect_at(1, 1'b1, 3'd2, "R8");
        tick(2);
        irq_in = 8'h20; isr_reg = 8'h0C;
        expect_at(2, 1'b0, 3'd0, "R8");
        tick(2);
        isr_reg = 8'h04;
        expect_at(1, 1'b1, 3'd5, "R8");
        tick(2);
        nest_en = 1'b0;
        expect_at(1, 1'b0, 3'd0, "R8");
        tick(2);

        tick(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule